// File: doc/BRIEF.md
# BCD Real-Time Calendar Core

This core keeps wall-clock time and calendar date on a slow real-time clock. Two counters run in series and divide that clock down to a once-per-second step. The first counter divides by (A+1) and the second by (S+1). Each step advances packed BCD time and date words through seconds, minutes, hours, day of month, weekday, month and year. Month lengths and leap years are handled inside the core.

Software writes a new time and date through a single load strobe. A hold input stops the core while a consistent pair of words is prepared. The live words drive the outputs continuously, so a reader needs no synchronisation step.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time word reads 0x000000 (00:00:00) and the date word reads 0x002101 (day 01, month 01, weekday 1, year 00).
- R2: With hold low and no load, the calendar advances exactly once every (A+1)*(S+1) clock cycles. A is `async_div_i` and S is `sync_div_i`, both counted from the last load or reset.
- R3: Seconds (time bits 6:0) and minutes (time bits 14:8) are BCD, wrap from 59 to 00, and each wrap carries one into the next field.
- R4: Hours (time bits 21:16) run 00 to 23 in BCD. The 23 to 00 wrap advances the day.
- R5: Day of month (date bits 5:0, BCD) wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except 02. Each wrap advances the month (date bits 12:8, BCD).
- R6: February ends on day 29 when the two-digit year is divisible by four, year 00 included, and on day 28 otherwise.
- R7: Month wraps from 12 to 01 and advances the year (date bits 23:16, BCD). Year 99 wraps to 00.
- R8: Weekday (date bits 15:13, binary 1 to 7) advances with every day change and wraps from 7 to 1.
- R9: While hold is high and load is low, both prescaler counters and both words stay frozen.
- R10: A load strobe writes the time and date inputs to the outputs on the next edge and restarts both prescalers, whether or not hold is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Real-time clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| async_div_i | input | 7 | First-stage reload value A |
| sync_div_i | input | 15 | Second-stage reload value S |
| hold_i | input | 1 | Freeze prescalers and calendar |
| load_i | input | 1 | Write new time and date words |
| time_i | input | 22 | New time word |
| date_i | input | 24 | New date word |
| time_o | output | 22 | Live BCD time word |
| date_o | output | 24 | Live BCD date word |

## Verification
The rare cases are rollovers: the last second of a month end, of a leap-year February, or of year 99. Reaching them from reset would take years of simulated time. The stimulus loads a word a single second before each boundary, with both dividers set to 1 so that one second is four cycles. It then samples one second later. Hold and restart are checked by counting edges around a load, with the words left unchanged by an extra step.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int TIME_W = 22;
  localparam int DATE_W = 24;

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return {3'd0, v[7:4]} * 7'd10 + {3'd0, v[3:0]};
  endfunction

  // last day of month, BCD
  function automatic logic [5:0] month_last_day(input logic [4:0] mon, input logic [7:0] yr);
    logic [6:0] m;
    logic [6:0] y;
    m = bcd_to_bin({3'd0, mon});
    y = bcd_to_bin(yr);
    case (m)
      7'd2:                      return (y[1:0] == 2'd0) ? 6'h29 : 6'h28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 6'h30;
      default:                   return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (en_i)      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cal_time.sv
module cal_time (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [21:0] time_i,
  input  logic        step_i,
  output logic [21:0] time_o,
  output logic        day_step_o
);
  logic [6:0] sec_q, min_q, sec_nx, min_nx;
  logic [5:0] hr_q, hr_nx;
  logic       sec_top, min_top, hr_top;

  assign sec_top = (sec_q == 7'h59);
  assign min_top = (min_q == 7'h59);
  assign hr_top  = (hr_q == 6'h23);

  assign sec_nx = (sec_q[3:0] == 4'd9) ? {sec_q[6:4] + 3'd1, 4'd0} : {sec_q[6:4], sec_q[3:0] + 4'd1};
  assign min_nx = (min_q[3:0] == 4'd9) ? {min_q[6:4] + 3'd1, 4'd0} : {min_q[6:4], min_q[3:0] + 4'd1};
  assign hr_nx  = (hr_q[3:0] == 4'd9)  ? {hr_q[5:4] + 2'd1, 4'd0}  : {hr_q[5:4], hr_q[3:0] + 4'd1};

  assign day_step_o = step_i && sec_top && min_top && hr_top;
  assign time_o     = {hr_q, 1'b0, min_q, 1'b0, sec_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
    end else if (load_i) begin
      sec_q <= time_i[6:0];
      min_q <= time_i[14:8];
      hr_q  <= time_i[21:16];
    end else if (step_i) begin
      sec_q <= sec_top ? 7'h00 : sec_nx;
      if (sec_top) begin
        min_q <= min_top ? 7'h00 : min_nx;
        if (min_top) hr_q <= hr_top ? 6'h00 : hr_nx;
      end
    end
  end
endmodule

// File: rtl/cal_date.sv
module cal_date
  import cal_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [23:0] date_i,
  input  logic        step_i,
  output logic [23:0] date_o
);
  logic [5:0] day_q, day_nx, last_day;
  logic [4:0] mon_q, mon_nx;
  logic [2:0] wd_q;
  logic [7:0] yr_q, yr_nx;
  logic       day_top, mon_top;

  assign last_day = month_last_day(mon_q, yr_q);
  assign day_top  = (day_q == last_day);
  assign mon_top  = (mon_q == 5'h12);

  assign day_nx = (day_q[3:0] == 4'd9) ? {day_q[5:4] + 2'd1, 4'd0} : {day_q[5:4], day_q[3:0] + 4'd1};
  assign mon_nx = (mon_q[3:0] == 4'd9) ? 5'h10 : {mon_q[4], mon_q[3:0] + 4'd1};
  assign yr_nx  = (yr_q[3:0] == 4'd9)  ? {yr_q[7:4] + 4'd1, 4'd0} : {yr_q[7:4], yr_q[3:0] + 4'd1};

  assign date_o = {yr_q, wd_q, mon_q, 2'b00, day_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      day_q <= 6'h01;
      mon_q <= 5'h01;
      wd_q  <= 3'd1;
      yr_q  <= 8'h00;
    end else if (load_i) begin
      day_q <= date_i[5:0];
      mon_q <= date_i[12:8];
      wd_q  <= date_i[15:13];
      yr_q  <= date_i[23:16];
    end else if (step_i) begin
      day_q <= day_top ? 6'h01 : day_nx;
      wd_q  <= (wd_q == 3'd7) ? 3'd1 : wd_q + 3'd1;
      if (day_top) begin
        mon_q <= mon_top ? 5'h01 : mon_nx;
        if (mon_top) yr_q <= (yr_q == 8'h99) ? 8'h00 : yr_nx;
      end
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int ADIV_W = 7,
  parameter int SDIV_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADIV_W-1:0] async_div_i,
  input  logic [SDIV_W-1:0] sync_div_i,
  input  logic              hold_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [DATE_W-1:0] date_i,
  output logic [TIME_W-1:0] time_o,
  output logic [DATE_W-1:0] date_o
);
  logic run, a_tick, sec_tick, day_step;
  logic unused_bits;

  assign run         = !hold_i && !load_i;
  assign unused_bits = ^{time_i[15], time_i[7], date_i[7:6]};

  cal_prescaler #(.W(ADIV_W)) u_apre (
    .clk_i, .rst_ni, .restart_i(load_i), .en_i(run),
    .limit_i(async_div_i), .tick_o(a_tick)
  );

  cal_prescaler #(.W(SDIV_W)) u_spre (
    .clk_i, .rst_ni, .restart_i(load_i), .en_i(a_tick),
    .limit_i(sync_div_i), .tick_o(sec_tick)
  );

  cal_time u_time (
    .clk_i, .rst_ni, .load_i, .time_i, .step_i(sec_tick),
    .time_o, .day_step_o(day_step)
  );

  cal_date u_date (
    .clk_i, .rst_ni, .load_i, .date_i, .step_i(day_step), .date_o
  );
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        hold_i,
  input logic        load_i,
  input logic [21:0] time_i,
  input logic [23:0] date_i,
  input logic [21:0] time_o,
  input logic [23:0] date_o
);
  a_r10_load_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (time_o == $past(time_i)) && (date_o == $past(date_i)));

  a_r9_hold_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !load_i) |=> $stable(time_o) && $stable(date_o));

  a_r3_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && time_o[6:0] == 7'h59) |=> (time_o[6:0] == 7'h59 || time_o[6:0] == 7'h00));

  a_r4_hour_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_o[21:16] <= 6'h23);

  a_r8_wday_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    date_o[15:13] != 3'd0);

  a_r7_year_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && date_o[23:16] == 8'h99) |=> (date_o[23:16] == 8'h99 || date_o[23:16] == 8'h00));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .load_i(load_i),
  .time_i(time_i), .date_i(date_i), .time_o(time_o), .date_o(date_o)
);

// File: tb/bcd_calendar_tb.sv
`timescale 1ns/1ps
module bcd_calendar_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  async_div_i = 7'd1;
  logic [14:0] sync_div_i = 15'd1;
  logic        hold_i = 1'b0;
  logic        load_i = 1'b0;
  logic [21:0] time_i = '0;
  logic [23:0] date_i = '0;
  logic [21:0] time_o;
  logic [23:0] date_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bcd_calendar u_dut (.*);

  typedef struct packed {
    logic [21:0] t_in;
    logic [23:0] d_in;
    logic [21:0] t_exp;
    logic [23:0] d_exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{22'h123456, 24'h236510, 22'h123457, 24'h236510, 4'd2},  // R2 plain second
    '{22'h123459, 24'h236510, 22'h123500, 24'h236510, 4'd3},  // R3 sec carry
    '{22'h125959, 24'h236510, 22'h130000, 24'h236510, 4'd3},  // R3 min carry
    '{22'h235959, 24'h236510, 22'h000000, 24'h238511, 4'd4},  // R4 day advance
    '{22'h235959, 24'h23E430, 22'h000000, 24'h232501, 4'd8},  // R8 wd 7->1, R5 Apr 30
    '{22'h235959, 24'h234530, 22'h000000, 24'h236531, 4'd5},  // R5 May 30->31
    '{22'h235959, 24'h23C930, 22'h000000, 24'h23F001, 4'd5},  // R5 Sep 30 -> Oct
    '{22'h235959, 24'h232131, 22'h000000, 24'h234201, 4'd5},  // R5 Jan 31
    '{22'h235959, 24'h234228, 22'h000000, 24'h236301, 4'd6},  // R6 non-leap Feb 28
    '{22'h235959, 24'h246228, 22'h000000, 24'h248229, 4'd6},  // R6 leap Feb 28
    '{22'h235959, 24'h248229, 22'h000000, 24'h24A301, 4'd6},  // R6 leap Feb 29
    '{22'h235959, 24'h002228, 22'h000000, 24'h004229, 4'd6},  // R6 year 00 leap
    '{22'h235959, 24'h23F231, 22'h000000, 24'h242101, 4'd7},  // R7 Dec 31 -> year
    '{22'h235959, 24'h99B231, 22'h000000, 24'h00C101, 4'd7}   // R7 year 99 -> 00
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [21:0] t, input logic [23:0] d);
    load_i = 1'b1; time_i = t; date_i = d;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    // R1 reset values
    check("R1 time", {2'b0, time_o}, 24'h000000);
    check("R1 date", date_o, 24'h002101);

    // table walk, A=1 S=1: one second = 4 cycles
    for (int i = 0; i < NV; i++) begin
      do_load(VECS[i].t_in, VECS[i].d_in);
      step(4);
      check($sformatf("R%0d time v%0d", VECS[i].req, i), {2'b0, time_o}, {2'b0, VECS[i].t_exp});
      check($sformatf("R%0d date v%0d", VECS[i].req, i), date_o, VECS[i].d_exp);
    end

    // R10 load visible next edge
    do_load(22'h010203, 24'h236510);
    check("R10 load time", {2'b0, time_o}, 24'h010203);
    // R10 restart: reload mid-second, then count full period again
    step(3);
    do_load(22'h010203, 24'h236510);
    step(3);
    check("R10 restart early", {2'b0, time_o}, 24'h010203);
    step(1);
    check("R10 restart tick", {2'b0, time_o}, 24'h010204);

    // R2 period with A=2 S=3 -> 12 cycles
    async_div_i = 7'd2; sync_div_i = 15'd3;
    do_load(22'h000000, 24'h236510);
    step(11);
    check("R2 before period", {2'b0, time_o}, 24'h000000);
    step(1);
    check("R2 at period", {2'b0, time_o}, 24'h000001);
    step(12);
    check("R2 second period", {2'b0, time_o}, 24'h000002);

    // R9 hold freezes prescalers and words
    async_div_i = 7'd1; sync_div_i = 15'd1;
    hold_i = 1'b1;
    do_load(22'h235959, 24'h99B231);
    step(20);
    check("R9 held time", {2'b0, time_o}, 24'h235959);
    check("R9 held date", date_o, 24'h99B231);
    hold_i = 1'b0;
    step(3);
    check("R9 resumed early", {2'b0, time_o}, 24'h235959);
    step(1);
    check("R9 resumed tick", {2'b0, time_o}, 24'h000000);
    check("R7 resumed date", date_o, 24'h00C101);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule